// File: doc/BRIEF.md
# Flash Status Register Protection Unit

This block keeps the eight-bit status byte of a serial flash device and rules on every command that could change the device's contents or its protection settings. A command decoder in front of it presents one decoded command per strobe, together with the target address and, for a status write, the new byte. The unit answers each strobe with exactly one accept or reject pulse. When it accepts a status write, a program or an erase, it runs a self-timed cycle and raises a busy flag for as long as that cycle lasts.

Protection has three layers. The first is a write-enable latch that must be set before any modifying command; every such command clears it when it completes. The second is a three-bit protect code that fences off an upper range of blocks. The third is a hardware lock. It holds while a status-write-disable bit is 1 and the active-low protect pin is low, and it makes the protect code and the disable bit read-only. The lock does not care which of the two conditions became true first, and it ends only when the pin rises.

The block retains its settings in plain registers. The memory array is outside this block.

Top module: `flash_sr_guard`

## Requirements
- R1: The status byte reads bit 0 = write in progress, bit 1 = write-enable latch, bits 4:2 = protect code, bit 7 = status-write-disable, and bits 6 and 5 always 0. After reset the byte is 00h and busy is low.
- R2: An accepted status write (op 3) changes only bits 7 and 4:2, taking them from data bits 7 and 4:2. The new values appear when its cycle completes, not before.
- R3: Write enable (op 1) sets the latch and write disable (op 2) clears it, both visible in the cycle after the strobe. Completion of an accepted status write, page program (op 4), sector erase (op 5), block erase (op 6) or chip erase (op 7) clears the latch.
- R4: Ops 3 to 7 are rejected whenever the latch is 0.
- R5: A status write is rejected while bit 7 is 1 and the protect pin is low, whichever of the two became true first. Raising the pin makes status writes acceptable again.
- R6: Blocks are selected by the top four address bits (16 blocks of a 20-bit address). Protect code 1 fences block 15, code 2 fences blocks 14–15, code 3 fences blocks 12–15, code 4 fences blocks 8–15, and codes 5–7 fence every block. Ops 4, 5 and 6 aimed at a fenced block are rejected.
- R7: Chip erase is accepted only when the protect code is 000.
- R8: An accepted op 3, 4, 5, 6 or 7 holds bit 0 and busy high for exactly LEN_WRSR, LEN_PROG, LEN_SECT, LEN_BLOCK or LEN_CHIP cycles (defaults 4, 6, 8, 10, 12), counted from the cycle after the strobe.
- R9: Each strobe yields exactly one of accept or reject, for one cycle, in the cycle after the strobe. A rejected command leaves the latch unchanged. Op 0 is always rejected.
- R10: Every command strobed while a cycle is running is rejected. The status byte stays readable during the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wp_n | input | 1 | Protect pin, active low |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_op | input | 3 | Command code: 0 none, 1 write enable, 2 write disable, 3 status write, 4 page program, 5 sector erase, 6 block erase, 7 chip erase |
| cmd_addr | input | ADDR_W | Target byte address |
| cmd_data | input | 8 | New status byte for a status write |
| status_o | output | 8 | Readable status byte |
| cmd_accept | output | 1 | Command accepted (one-cycle pulse) |
| cmd_reject | output | 1 | Command rejected (one-cycle pulse) |
| busy_o | output | 1 | Self-timed cycle running |

## Verification
The bench walks every protect code against the block just inside and the block just outside its fenced range, since an off-by-one in the range decode would either program a fenced block or refuse a free one. It sets the hardware lock in both orders and then releases it with the pin, so a design that latched the lock on an edge, or tied it to a fixed order, would accept or refuse the wrong status write. It also counts the busy cycles of each kind of command, sends a command in the middle of a cycle, and reads the status byte while a status write is still pending. A design that cleared the latch on a rejected command, or applied the new protect code early, would show the wrong byte at one of those reads.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_WEN   = 3'd1,
    OP_WDIS  = 3'd2,
    OP_SRWR  = 3'd3,
    OP_PROG  = 3'd4,
    OP_SECT  = 3'd5,
    OP_BLOCK = 3'd6,
    OP_CHIP  = 3'd7
  } fsr_op_e;

  localparam int unsigned SR_W      = 8;
  localparam int unsigned BIT_WIP   = 0;
  localparam int unsigned BIT_WEL   = 1;
  localparam int unsigned BIT_PR_LO = 2;
  localparam int unsigned BIT_LOCK  = 7;
  localparam int unsigned PCODE_W   = 3;

  // ops 3..7 modify contents or settings and need the latch
  function automatic logic op_modifies(input logic [2:0] op);
    return op >= 3'(OP_SRWR);
  endfunction

  // ops that run a self-timed cycle (same set as the modifying ops)
  function automatic logic op_timed(input logic [2:0] op);
    return op_modifies(op);
  endfunction

  // ops that target one block of the array
  function automatic logic op_targets_block(input logic [2:0] op);
    return (op == 3'(OP_PROG)) || (op == 3'(OP_SECT)) || (op == 3'(OP_BLOCK));
  endfunction

  // upper-range fence: code c in 1..blk_w fences the top (2^blk_w >> (blk_w+1-c)) blocks,
  // codes above blk_w fence all blocks, code 0 fences nothing
  function automatic logic block_fenced(input logic [2:0] pcode,
                                        input int unsigned blk,
                                        input int unsigned blk_w);
    int unsigned nblk;
    int unsigned span;
    nblk = 32'd1 << blk_w;
    if (pcode == 3'd0) return 1'b0;
    if (int'(pcode) > int'(blk_w)) return 1'b1;
    span = nblk >> (blk_w + 1 - int'(pcode));
    return blk >= (nblk - span);
  endfunction

  // assemble the readable byte; bits 6:5 are hard zero
  function automatic logic [7:0] pack_status(input logic lock, input logic [2:0] pcode,
                                             input logic wel, input logic wip);
    return {lock, 2'b00, pcode, wel, wip};
  endfunction

endpackage

// File: rtl/fsr_cmd_judge.sv
module fsr_cmd_judge
  import fsr_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned BLK_W  = 4
) (
  input  logic              valid_i,
  input  logic [2:0]        op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              busy_i,
  input  logic              wel_i,
  input  logic              lock_i,
  input  logic [2:0]        pcode_i,
  input  logic              wp_n_i,
  output logic              ok_o,
  output logic              bad_o,
  output logic              hw_lock_o,
  output logic              fenced_o
);

  localparam int unsigned BLK_HI = ADDR_W - 1;

  logic [BLK_W-1:0] blk_idx;
  logic             verdict;

  assign blk_idx   = addr_i[BLK_HI -: BLK_W];
  assign hw_lock_o = lock_i & ~wp_n_i;
  assign fenced_o  = block_fenced(pcode_i, int'(blk_idx), BLK_W);

  always_comb begin
    verdict = 1'b0;
    if (!busy_i) begin
      unique case (op_i)
        3'(OP_WEN), 3'(OP_WDIS): verdict = 1'b1;
        3'(OP_SRWR):             verdict = wel_i & ~hw_lock_o;
        3'(OP_PROG), 3'(OP_SECT), 3'(OP_BLOCK):
                                 verdict = wel_i & ~fenced_o;
        3'(OP_CHIP):             verdict = wel_i & (pcode_i == 3'd0);
        default:                 verdict = 1'b0;
      endcase
    end
  end

  assign ok_o  = valid_i & verdict;
  assign bad_o = valid_i & ~verdict;

endmodule

// File: rtl/fsr_cycle_timer.sv
module fsr_cycle_timer
  import fsr_pkg::*;
#(
  parameter int unsigned LEN_WRSR  = 4,
  parameter int unsigned LEN_PROG  = 6,
  parameter int unsigned LEN_SECT  = 8,
  parameter int unsigned LEN_BLOCK = 10,
  parameter int unsigned LEN_CHIP  = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [2:0] op_i,
  output logic       active_o,
  output logic       done_o
);

  localparam int unsigned MAX_A = (LEN_WRSR > LEN_PROG) ? LEN_WRSR : LEN_PROG;
  localparam int unsigned MAX_B = (LEN_SECT > LEN_BLOCK) ? LEN_SECT : LEN_BLOCK;
  localparam int unsigned MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned MAX_LEN = (MAX_C > LEN_CHIP) ? MAX_C : LEN_CHIP;
  localparam int unsigned CNT_W = (MAX_LEN < 2) ? 1 : $clog2(MAX_LEN);

  logic [CNT_W-1:0] remain;
  logic             running;

  // cycles left after the first, per op kind
  function automatic logic [CNT_W-1:0] reload(input logic [2:0] op);
    int unsigned n;
    unique case (op)
      3'(OP_SRWR):  n = LEN_WRSR;
      3'(OP_PROG):  n = LEN_PROG;
      3'(OP_SECT):  n = LEN_SECT;
      3'(OP_BLOCK): n = LEN_BLOCK;
      default:      n = LEN_CHIP;
    endcase
    return CNT_W'(n - 1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      remain  <= '0;
    end else if (start_i) begin
      running <= 1'b1;
      remain  <= reload(op_i);
    end else if (running) begin
      if (remain == '0) running <= 1'b0;
      else              remain  <= remain - 1'b1;
    end
  end

  assign active_o = running;
  assign done_o   = running && (remain == '0);

endmodule

// File: rtl/fsr_reg_bank.sv
module fsr_reg_bank
  import fsr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wel_set_i,
  input  logic       wel_clr_i,
  input  logic       stage_i,
  input  logic [3:0] stage_val_i,
  input  logic       done_i,
  output logic       wel_o,
  output logic       lock_o,
  output logic [2:0] pcode_o
);

  logic       wel_q;
  logic       lock_q;
  logic [2:0] pcode_q;
  logic [3:0] staged_q;
  logic       staged_v;

  // latch: set/clear by command, cleared when any timed cycle ends
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         wel_q <= 1'b0;
    else if (wel_set_i) wel_q <= 1'b1;
    else if (wel_clr_i) wel_q <= 1'b0;
    else if (done_i)    wel_q <= 1'b0;
  end

  // new settings wait for the end of the status-write cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      staged_q <= '0;
      staged_v <= 1'b0;
      lock_q   <= 1'b0;
      pcode_q  <= '0;
    end else begin
      if (stage_i) begin
        staged_q <= stage_val_i;
        staged_v <= 1'b1;
      end else if (done_i && staged_v) begin
        lock_q   <= staged_q[3];
        pcode_q  <= staged_q[2:0];
        staged_v <= 1'b0;
      end
    end
  end

  assign wel_o   = wel_q;
  assign lock_o  = lock_q;
  assign pcode_o = pcode_q;

endmodule

// File: rtl/flash_sr_guard.sv
module flash_sr_guard
  import fsr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 20,
  parameter int unsigned BLK_W     = 4,
  parameter int unsigned LEN_WRSR  = 4,
  parameter int unsigned LEN_PROG  = 6,
  parameter int unsigned LEN_SECT  = 8,
  parameter int unsigned LEN_BLOCK = 10,
  parameter int unsigned LEN_CHIP  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_data,
  output logic [7:0]        status_o,
  output logic              cmd_accept,
  output logic              cmd_reject,
  output logic              busy_o
);

  // named internal events, brought out for the checker
  logic       judge_ok;
  logic       judge_bad;
  logic       hw_lock;
  logic       fenced;
  logic       cycle_start;
  logic       cycle_busy;
  logic       cycle_done;
  logic       wel;
  logic       lock_bit;
  logic [2:0] pcode;
  logic       acc_q;
  logic       rej_q;

  fsr_cmd_judge #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_judge (
    .valid_i  (cmd_valid),
    .op_i     (cmd_op),
    .addr_i   (cmd_addr),
    .busy_i   (cycle_busy),
    .wel_i    (wel),
    .lock_i   (lock_bit),
    .pcode_i  (pcode),
    .wp_n_i   (wp_n),
    .ok_o     (judge_ok),
    .bad_o    (judge_bad),
    .hw_lock_o(hw_lock),
    .fenced_o (fenced)
  );

  assign cycle_start = judge_ok & op_timed(cmd_op);

  fsr_cycle_timer #(
    .LEN_WRSR(LEN_WRSR), .LEN_PROG(LEN_PROG), .LEN_SECT(LEN_SECT),
    .LEN_BLOCK(LEN_BLOCK), .LEN_CHIP(LEN_CHIP)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (cycle_start),
    .op_i    (cmd_op),
    .active_o(cycle_busy),
    .done_o  (cycle_done)
  );

  fsr_reg_bank u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .wel_set_i  (judge_ok && cmd_op == 3'(OP_WEN)),
    .wel_clr_i  (judge_ok && cmd_op == 3'(OP_WDIS)),
    .stage_i    (judge_ok && cmd_op == 3'(OP_SRWR)),
    .stage_val_i({cmd_data[BIT_LOCK], cmd_data[BIT_PR_LO +: PCODE_W]}),
    .done_i     (cycle_done),
    .wel_o      (wel),
    .lock_o     (lock_bit),
    .pcode_o    (pcode)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= 1'b0;
      rej_q <= 1'b0;
    end else begin
      acc_q <= judge_ok;
      rej_q <= judge_bad;
    end
  end

  assign status_o   = pack_status(lock_bit, pcode, wel, cycle_busy);
  assign cmd_accept = acc_q;
  assign cmd_reject = rej_q;
  assign busy_o     = cycle_busy;

endmodule

// File: rtl/fsr_guard_checker.sv
module fsr_guard_checker
  import fsr_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       wp_n,
  input logic       cmd_valid,
  input logic [2:0] cmd_op,
  input logic [7:0] status_o,
  input logic       cmd_accept,
  input logic       cmd_reject,
  input logic       busy_o,
  input logic       cycle_done
);

  assert_zero_bits_R1: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[6:5] == 2'b00);

  assert_wip_mirrors_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[0] == busy_o);

  assert_wen_sets_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'(OP_WEN) && !busy_o) |=> status_o[1]);

  assert_no_latch_reject_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && op_modifies(cmd_op) && !status_o[1]) |=> cmd_reject);

  assert_hw_lock_reject_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'(OP_SRWR) && status_o[7] && !wp_n) |=> cmd_reject);

  assert_chip_needs_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'(OP_CHIP) && status_o[4:2] != 3'd0) |=> cmd_reject);

  assert_done_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_done |=> (!busy_o && !status_o[1]));

  assert_one_verdict_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> (cmd_accept ^ cmd_reject));

  assert_no_spurious_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> (!cmd_accept && !cmd_reject));

  assert_reject_keeps_latch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy_o && !cycle_done && cmd_op != 3'(OP_WEN) && cmd_op != 3'(OP_WDIS))
      |=> (status_o[1] == $past(status_o[1])) || cmd_accept);

  assert_busy_rejects_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && busy_o) |=> cmd_reject);

endmodule

bind flash_sr_guard fsr_guard_checker u_chk (.*);

// File: tb/tb_flash_sr_guard.sv
module tb_flash_sr_guard;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wp_n = 1'b1;
  logic          cmd_valid = 1'b0;
  logic [2:0]    cmd_op = 3'd0;
  logic [AW-1:0] cmd_addr = '0;
  logic [7:0]    cmd_data = 8'h00;
  logic [7:0]    status_o;
  logic          cmd_accept, cmd_reject, busy_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit reported = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_sr_guard dut (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .status_o(status_o),
    .cmd_accept(cmd_accept), .cmd_reject(cmd_reject), .busy_o(busy_o)
  );

  // op codes restated from the requirements
  localparam logic [2:0] NOP = 3'd0, WEN = 3'd1, WDS = 3'd2, SRW = 3'd3,
                         PRG = 3'd4, SEC = 3'd5, BLK = 3'd6, CHP = 3'd7;

  // vector: op, addr, data, pin, expect-accept, status after completion, busy length
  function automatic logic [45:0] v(input logic [2:0] op, input logic [19:0] a,
                                    input logic [7:0] d, input logic p, input logic acc,
                                    input logic [7:0] sr, input logic [4:0] len);
    return {op, a, d, p, acc, sr, len};
  endfunction

  localparam int NV = 40;
  localparam logic [45:0] VEC [NV] = '{
    v(PRG, 20'h00000, 8'h00, 1, 0, 8'h00, 0),  // R4 no latch
    v(WEN, 20'h0,     8'h00, 1, 1, 8'h02, 0),  // R3
    v(WDS, 20'h0,     8'h00, 1, 1, 8'h00, 0),  // R3
    v(WEN, 20'h0,     8'h00, 1, 1, 8'h02, 0),
    v(SRW, 20'h0,     8'hFF, 1, 1, 8'h9C, 4),  // R2 only 7,4:2 taken
    v(WEN, 20'h0,     8'h00, 1, 1, 8'h9E, 0),
    v(SEC, 20'h00000, 8'h00, 1, 0, 8'h9E, 0),  // R6 code 7, R9 latch kept
    v(SRW, 20'h0,     8'h00, 0, 0, 8'h9E, 0),  // R5 lock
    v(SRW, 20'h0,     8'h04, 1, 1, 8'h04, 4),  // R5 pin high releases
    v(WEN, 20'h0,     8'h00, 1, 1, 8'h06, 0),
    v(BLK, 20'hF0000, 8'h00, 1, 0, 8'h06, 0),  // R6 code 1 block 15
    v(PRG, 20'hEFFFF, 8'h00, 1, 1, 8'h04, 6),  // R6 block 14 free
    v(WEN, 20'h0,     8'h00, 1, 1, 8'h06, 0),
    v(CHP, 20'h0,     8'h00, 1, 0, 8'h06, 0),  // R7
    v(SRW, 20'h0,     8'h08, 1, 1, 8'h08, 4),
    v(WEN, 20'h0,     8'h00, 1, 1, 8'h0A, 0),
    v(SEC, 20'hE0000, 8'h00, 1, 0, 8'h0A, 0),  // R6 code 2
    v(SEC, 20'hD0000, 8'h00, 1, 1, 8'h08, 8),
    v(WEN, 20'h0,     8'h00, 1, 1, 8'h0A, 0),
    v(SRW, 20'h0,     8'h0C, 1, 1, 8'h0C, 4),
    v(WEN, 20'h0,     8'h00, 1, 1, 8'h0E, 0),
    v(SEC, 20'hC0000, 8'h00, 1, 0, 8'h0E, 0),  // R6 code 3
    v(BLK, 20'hB0000, 8'h00, 1, 1, 8'h0C, 10),
    v(WEN, 20'h0,     8'h00, 1, 1, 8'h0E, 0),
    v(SRW, 20'h0,     8'h10, 1, 1, 8'h10, 4),
    v(WEN, 20'h0,     8'h00, 1, 1, 8'h12, 0),
    v(PRG, 20'h80000, 8'h00, 1, 0, 8'h12, 0),  // R6 code 4
    v(PRG, 20'h7FFFF, 8'h00, 1, 1, 8'h10, 6),
    v(WEN, 20'h0,     8'h00, 1, 1, 8'h12, 0),
    v(SRW, 20'h0,     8'h14, 1, 1, 8'h14, 4),
    v(WEN, 20'h0,     8'h00, 1, 1, 8'h16, 0),
    v(PRG, 20'h00000, 8'h00, 1, 0, 8'h16, 0),  // R6 code 5
    v(SRW, 20'h0,     8'h00, 1, 1, 8'h00, 4),
    v(WEN, 20'h0,     8'h00, 1, 1, 8'h02, 0),
    v(CHP, 20'h0,     8'h00, 1, 1, 8'h00, 12), // R7 code 0
    v(WEN, 20'h0,     8'h00, 1, 1, 8'h02, 0),
    v(SRW, 20'h0,     8'h80, 0, 1, 8'h80, 4),  // R5 pin low first, then bit set
    v(WEN, 20'h0,     8'h00, 0, 1, 8'h82, 0),
    v(SRW, 20'h0,     8'h00, 0, 0, 8'h82, 0),  // R5 now locked
    v(SRW, 20'h0,     8'h00, 1, 1, 8'h00, 4)   // R5 released
  };

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  // drive at a falling edge, strobe for one cycle; return after the verdict edge
  task automatic issue(input logic [2:0] op, input logic [19:0] a,
                       input logic [7:0] d, input logic p);
    @(negedge clk);
    cmd_op = op; cmd_addr = a; cmd_data = d; wp_n = p; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd0;
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (status_o[0] && n < 64) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    if (!reported) begin
      reported = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    int len;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset status", status_o, 8'h00);
    chk("R1 reset busy", busy_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 op 0 rejected
    issue(NOP, 20'h0, 8'h00, 1);
    chk("R9 none accept", cmd_accept, 0);
    chk("R9 none reject", cmd_reject, 1);

    for (int i = 0; i < NV; i++) begin
      logic [45:0] e;
      e = VEC[i];
      issue(e[45:43], e[42:23], e[22:15], e[14]);
      chk($sformatf("R9 vec%0d accept", i), cmd_accept, e[13]);
      chk($sformatf("R9 vec%0d reject", i), cmd_reject, !e[13]);
      if (e[4:0] != 0) begin
        busy_len(len);
        chk($sformatf("R8 vec%0d busy cycles", i), len, e[4:0]);
      end
      chk($sformatf("R2 R3 R6 vec%0d status", i), status_o, e[12:5]);
      chk($sformatf("R1 vec%0d busy pin", i), busy_o, status_o[0]);
    end

    // R10: strobe during a sector erase is rejected; status readable mid-cycle
    issue(WEN, 20'h0, 8'h00, 1);
    issue(SEC, 20'h10000, 8'h00, 1);
    chk("R10 erase accepted", cmd_accept, 1);
    @(negedge clk);
    issue(WEN, 20'h0, 8'h00, 1);
    chk("R10 busy reject", cmd_reject, 1);
    chk("R10 mid-cycle status", status_o, 8'h03);
    busy_len(len);
    chk("R3 latch cleared at end", status_o, 8'h00);

    // R2: staged settings invisible until completion
    issue(WEN, 20'h0, 8'h00, 1);
    issue(SRW, 20'h0, 8'h1C, 1);
    chk("R2 old bits during cycle", status_o, 8'h03);
    busy_len(len);
    chk("R2 new bits after cycle", status_o, 8'h1C);
    // R9: rejected erase keeps latch set
    issue(WEN, 20'h0, 8'h00, 1);
    issue(BLK, 20'h00000, 8'h00, 1);
    chk("R9 reject keeps latch", status_o, 8'h1E);
    issue(SRW, 20'h0, 8'h00, 1);
    busy_len(len);
    chk("R2 restore", status_o, 8'h00);

    finish_run();
  end

endmodule